// File: doc/BRIEF.md
# Invalidate/Update Acknowledge Tracker

This block sits on the processor side of a system bus. It tracks one coherence request at a time, either an invalidate or an update, from the moment the request is issued until the external agent resolves it. While a request is outstanding the tracker holds its line address, its kind and the tag of the store that produced it. It raises an unacknowledged flag for as long as the request is open.

A request can be resolved in one of three ways. The agent can assert the active-low acknowledge pin, and the tracker then emits a completion pulse. The agent can assert the active-low error pin, and the tracker then emits a bus-error pulse that carries the originating store's tag. Third, an incoming external invalidate, update, snoop or intervention request can cancel it. The tracker then emits a retry pulse so that the cache controller checks the line again. If the line has become invalid, the controller services the store as a read miss. The acknowledge and error pins are dedicated, so they may be active in the same cycle as any other bus traffic. Both request kinds share these two pins.

Issue uses a valid/ready handshake. A request is taken in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as a request is unacknowledged. A source that sees `req_ready` low must keep its request, and it is held off until the open request resolves. Acknowledge or error activity while nothing is outstanding has no effect on the resolution outputs. Such activity sets a sticky protocol-violation flag.

Top module: `ivu_ack_tracker`

## Requirements
- R1: After reset, `pending`, `done_pulse`, `berr_pulse`, `retry_pulse` and `proto_viol` are 0 and `req_ready` is 1.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `pending` reads 1 from the next cycle. While `pending` is 1, `req_ready` is 0 and further `req_valid` is not accepted.
- R3: At an edge where `pending` is 1, `ack_n` is 0 and `err_n` is 1, the request resolves. In the next cycle `pending` is 0 and `done_pulse` is 1. `out_addr`, `out_kind` and `out_tag` then carry the accepted request's address, kind and tag.
- R4: At an edge where `pending` is 1 and `err_n` is 0, the request resolves. In the next cycle `pending` is 0 and `berr_pulse` is 1, with the request's fields on `out_addr`, `out_kind` and `out_tag`.
- R5: At an edge where `pending` is 1, both pins are 1 and `xreq_cancel` is 1, the request resolves. In the next cycle `pending` is 0 and `retry_pulse` is 1, with the request's line address on `out_addr`.
- R6: When resolving conditions coincide, error wins over acknowledge and acknowledge wins over cancellation. Exactly one pulse is produced.
- R7: While `pending` is 1 and no resolving condition is present, `pending` stays 1 for any number of cycles. Both kinds behave alike on the shared pins: `req_kind` 0 is invalidate and 1 is update.
- R8: When `pending` is 0, `ack_n`, `err_n` and `xreq_cancel` produce no pulse and leave `pending` at 0. A 0 on `ack_n` or `err_n` in that state sets `proto_viol` from the next cycle, and it stays 1 until reset.
- R9: Each resolution pulse is high for exactly one cycle, and at most one of the three is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Issue request valid |
| req_ready | output | 1 | Tracker can take a request |
| req_addr | input | ADDR_W | Target line address |
| req_kind | input | 1 | 0 invalidate, 1 update |
| req_tag | input | TAG_W | Tag of originating store |
| ack_n | input | 1 | Active-low acknowledge pin |
| err_n | input | 1 | Active-low error pin |
| xreq_cancel | input | 1 | Incoming external request cancels the open one |
| pending | output | 1 | Request unacknowledged |
| done_pulse | output | 1 | Request completed |
| berr_pulse | output | 1 | Request failed; bus error on the store |
| retry_pulse | output | 1 | Request cancelled; re-examine line |
| out_addr | output | ADDR_W | Address of the resolved request |
| out_kind | output | 1 | Kind of the resolved request |
| out_tag | output | TAG_W | Store tag of the resolved request |
| proto_viol | output | 1 | Sticky stray acknowledge/error flag |

## Verification
Error, acknowledge and cancellation can all land on the same edge, because the pins run beside ordinary external traffic. The bench drives every non-empty combination of the three for both request kinds and after several waiting times. It computes the single expected pulse from the priority order, then checks that the other two pulses are low and that the reported fields match the held request. It also keeps a second request valid during the wait, to confirm that it is held off.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  typedef enum logic {
    KIND_INV = 1'b0,
    KIND_UPD = 1'b1
  } kind_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_DONE  = 2'd1,
    RES_BERR  = 2'd2,
    RES_RETRY = 2'd3
  } res_e;
endpackage

// File: rtl/ivu_resolve_arb.sv
module ivu_resolve_arb
  import ivu_pkg::*;
(
  input  logic busy,
  input  logic ack_n,
  input  logic err_n,
  input  logic cancel,
  output res_e res,
  output logic stray
);
  logic ack, err;
  assign ack = ~ack_n;
  assign err = ~err_n;

  always_comb begin
    res = RES_NONE;
    if (busy) begin
      if (err)         res = RES_BERR;
      else if (ack)    res = RES_DONE;
      else if (cancel) res = RES_RETRY;
    end
  end

  assign stray = ~busy & (ack | err);
endmodule

// File: rtl/ivu_slot.sv
module ivu_slot
  import ivu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [ADDR_W-1:0] in_addr,
  input  kind_e             in_kind,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              busy,
  output logic [ADDR_W-1:0] hold_addr,
  output kind_e             hold_kind,
  output logic [TAG_W-1:0]  hold_tag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      hold_addr <= '0;
      hold_kind <= KIND_INV;
      hold_tag  <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      hold_addr <= in_addr;
      hold_kind <= in_kind;
      hold_tag  <= in_tag;
    end else if (clear) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ivu_report.sv
module ivu_report
  import ivu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  res_e              res,
  input  logic              stray,
  input  logic [ADDR_W-1:0] src_addr,
  input  kind_e             src_kind,
  input  logic [TAG_W-1:0]  src_tag,
  output logic              done_pulse,
  output logic              berr_pulse,
  output logic              retry_pulse,
  output logic [ADDR_W-1:0] out_addr,
  output kind_e             out_kind,
  output logic [TAG_W-1:0]  out_tag,
  output logic              viol
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_pulse  <= 1'b0;
      berr_pulse  <= 1'b0;
      retry_pulse <= 1'b0;
      out_addr    <= '0;
      out_kind    <= KIND_INV;
      out_tag     <= '0;
      viol        <= 1'b0;
    end else begin
      done_pulse  <= (res == RES_DONE);
      berr_pulse  <= (res == RES_BERR);
      retry_pulse <= (res == RES_RETRY);
      if (res != RES_NONE) begin
        out_addr <= src_addr;
        out_kind <= src_kind;
        out_tag  <= src_tag;
      end
      if (stray) viol <= 1'b1;
    end
  end
endmodule

// File: rtl/ivu_ack_tracker.sv
module ivu_ack_tracker
  import ivu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_kind,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              ack_n,
  input  logic              err_n,
  input  logic              xreq_cancel,
  output logic              pending,
  output logic              done_pulse,
  output logic              berr_pulse,
  output logic              retry_pulse,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_kind,
  output logic [TAG_W-1:0]  out_tag,
  output logic              proto_viol
);
  logic              busy, stray, load;
  res_e              res;
  logic [ADDR_W-1:0] h_addr;
  kind_e             h_kind, o_kind;
  logic [TAG_W-1:0]  h_tag;

  assign req_ready = ~busy;
  assign load      = req_valid & ~busy;
  assign pending   = busy;
  assign out_kind  = o_kind;

  ivu_resolve_arb u_arb (
    .busy(busy), .ack_n(ack_n), .err_n(err_n), .cancel(xreq_cancel),
    .res(res), .stray(stray)
  );

  ivu_slot #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(load), .clear(res != RES_NONE),
    .in_addr(req_addr), .in_kind(kind_e'(req_kind)), .in_tag(req_tag),
    .busy(busy), .hold_addr(h_addr), .hold_kind(h_kind), .hold_tag(h_tag)
  );

  ivu_report #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .res(res), .stray(stray),
    .src_addr(h_addr), .src_kind(h_kind), .src_tag(h_tag),
    .done_pulse(done_pulse), .berr_pulse(berr_pulse), .retry_pulse(retry_pulse),
    .out_addr(out_addr), .out_kind(o_kind), .out_tag(out_tag), .viol(proto_viol)
  );
endmodule

// File: rtl/ivu_ack_tracker_chk.sv
module ivu_ack_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ack_n,
  input logic err_n,
  input logic xreq_cancel,
  input logic pending,
  input logic done_pulse,
  input logic berr_pulse,
  input logic retry_pulse,
  input logic proto_viol
);
  a_r2_held_off: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !req_ready);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> pending);
  a_r3_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack_n && err_n) |=> (done_pulse && !pending));
  a_r4_err_berr: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !err_n) |=> (berr_pulse && !pending));
  a_r5_cancel_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ack_n && err_n && xreq_cancel) |=> (retry_pulse && !pending));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ack_n && err_n && !xreq_cancel) |=> pending);
  a_r8_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !req_valid) |=> !(done_pulse || berr_pulse || retry_pulse) && !pending);
  a_r8_viol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && (!ack_n || !err_n)) |=> proto_viol);
  a_r8_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_viol |=> proto_viol);
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, berr_pulse, retry_pulse}));
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || berr_pulse || retry_pulse) |=> !(done_pulse || berr_pulse || retry_pulse));
endmodule

bind ivu_ack_tracker ivu_ack_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ack_n(ack_n), .err_n(err_n), .xreq_cancel(xreq_cancel), .pending(pending),
  .done_pulse(done_pulse), .berr_pulse(berr_pulse), .retry_pulse(retry_pulse),
  .proto_viol(proto_viol)
);

// File: tb/tb_ivu_ack_tracker.sv
`timescale 1ns/1ps
module tb_ivu_ack_tracker;
  localparam int AW = 8, TW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic ack_n = 1'b1, err_n = 1'b1, xreq_cancel = 1'b0;
  logic req_ready, pending, done_pulse, berr_pulse, retry_pulse, out_kind, proto_viol;
  logic [AW-1:0] out_addr;
  logic [TW-1:0] out_tag;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  ivu_ack_tracker #(.ADDR_W(AW), .TAG_W(TW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask

  initial begin
    #400000;
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    step; step;
    chk("R1 pending", pending, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 pulses", {done_pulse, berr_pulse, retry_pulse}, 0);
    chk("R1 viol", proto_viol, 0);
    rst_n = 1'b1;
    step;
    // cancel while idle has no effect (R8)
    @(negedge clk); xreq_cancel = 1'b1;
    step; @(negedge clk); xreq_cancel = 1'b0;
    chk("R8 idle cancel pulses", {done_pulse, berr_pulse, retry_pulse}, 0);
    chk("R8 idle cancel pending", pending, 0);
    for (int k = 0; k < 2; k++) begin
      for (int combo = 1; combo < 8; combo++) begin
        for (int wt = 0; wt < 3; wt++) begin
          logic [AW-1:0] a;
          logic [TW-1:0] t;
          logic [2:0] exp;
          a = AW'(k * 64 + combo * 8 + wt + 1);
          t = TW'(combo + wt + k);
          // expected pulse {done,berr,retry}: err > ack > cancel (R6)
          if (combo[1])      exp = 3'b010;
          else if (combo[0]) exp = 3'b100;
          else               exp = 3'b001;
          @(negedge clk);
          chk("R2 ready before issue", req_ready, 1);
          req_valid = 1'b1; req_addr = a; req_kind = k[0]; req_tag = t;
          step;
          chk("R2 pending after accept", pending, 1);
          chk("R2 ready low", req_ready, 0);
          @(negedge clk);
          req_addr = ~a; req_tag = ~t; req_kind = ~k[0]; // held off (R2)
          for (int w = 0; w < wt; w++) begin
            step;
            chk("R7 pending held", pending, 1);
            chk("R7 no pulse while waiting", {done_pulse, berr_pulse, retry_pulse}, 0);
            @(negedge clk);
          end
          req_valid = 1'b0;
          ack_n = ~combo[0]; err_n = ~combo[1]; xreq_cancel = combo[2];
          step;
          chk("R6 pulse select", {done_pulse, berr_pulse, retry_pulse}, {29'd0, exp});
          chk("R3 pending cleared", pending, 0);
          chk("R3 addr", out_addr, a);
          chk("R4 tag", out_tag, t);
          chk("R7 kind", out_kind, k[0]);
          if (exp == 3'b001) chk("R5 retry addr", out_addr, a);
          @(negedge clk);
          ack_n = 1'b1; err_n = 1'b1; xreq_cancel = 1'b0;
          step;
          chk("R9 single cycle pulse", {done_pulse, berr_pulse, retry_pulse}, 0);
          chk("R8 no stray viol", proto_viol, 0);
        end
      end
    end
    // stray acknowledge while idle (R8)
    @(negedge clk); ack_n = 1'b0;
    step; @(negedge clk); ack_n = 1'b1;
    chk("R8 stray ack pulses", {done_pulse, berr_pulse, retry_pulse}, 0);
    chk("R8 stray ack pending", pending, 0);
    chk("R8 viol set", proto_viol, 1);
    step; step;
    chk("R8 viol sticky", proto_viol, 1);
    @(negedge clk); err_n = 1'b0;
    step; @(negedge clk); err_n = 1'b1;
    chk("R8 stray err pulses", {done_pulse, berr_pulse, retry_pulse}, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule